// File: doc/BRIEF.md
# Fieldbus Slave Frame Receiver

This block sits behind a UART on a half-duplex multidrop serial bus and turns the stream of received bytes into frames. Each received byte arrives as an 8-bit value with a one-cycle valid strobe. The parser splits a frame into five parts: a 16-bit destination, a 16-bit function code, a length byte, a payload of that many bytes, and a 16-bit checksum.

The parser decides whether a frame is meant for this node. A frame can reach the node through its own unique identifier, through a configured group identifier, or through the broadcast identifier. The parser also decides whether the sender expects a reply.

Payload bytes of accepted frames are streamed out, each with its index. When an accepted frame ends, a one-cycle completion pulse reports good or bad status and an acknowledge-required flag. If the line goes quiet for longer than a programmable gap in the middle of a frame, the partial frame is dropped.

Top module: `fbus_frame_rx`

## Requirements
- R1: Bytes arrive in this order: destination high, destination low, function high, function low, length, payload, checksum high, checksum low. Every 16-bit field is sent upper byte first. When the completion pulse fires, `fct_code` equals the 16-bit function code of that frame.
- R2: Each payload byte of an accepted frame appears on `pl_byte` with `pl_valid` high for one cycle, in the cycle after it was received. `pl_index` counts 0, 1, 2 and so on within the frame.
- R3: The checksum is CRC-16 with polynomial 0x8005, initial value 0xFFFF and reflected (LSB-first) processing. It covers every byte from destination high through the last payload byte. The checksum high byte carries bits 15:8. `frame_ok` is 1 at completion when the checksum matches and 0 when it does not.
- R4: A destination in 1000..64999 that equals `node_id` is accepted. On a good checksum, `ack_req` is 1 together with the completion pulse.
- R5: A destination in 65000..65499 that equals `group_id` is accepted, with `ack_req` 0.
- R6: Destination 65535 is accepted by every node, with `ack_req` 0.
- R7: A frame addressed to 0, to a reserved value (1..999 or 65500..65534), or to another node is parsed to its end. It produces no completion pulse and no payload output.
- R8: A length byte above 200 is a framing error. If the frame is addressed to this node, the completion pulse fires one cycle after the length byte, with `frame_ok` 0. Nothing is streamed, and later bytes are ignored until an idle gap has passed.
- R9: A length of 0 is legal. The checksum bytes follow the length byte directly.
- R10: If `IDLE_CYCLES` clock cycles pass with no received byte while a frame is in progress, the partial frame is discarded. The next byte is then taken as destination high. Gaps shorter than this leave the frame intact.
- R11: `frame_done` is a single-cycle pulse that fires one cycle after the final checksum byte. `ack_req` is never 1 without `frame_done` and `frame_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte value |
| node_id | input | 16 | Unique identifier of this node |
| group_id | input | 16 | Group identifier of this node |
| fct_code | output | 16 | Function code of the current frame |
| pl_valid | output | 1 | Payload byte strobe |
| pl_byte | output | 8 | Payload byte |
| pl_index | output | 8 | Index of the payload byte within the frame |
| frame_done | output | 1 | Completion pulse of an accepted frame |
| frame_ok | output | 1 | Status with `frame_done`: 1 good, 0 checksum or length error |
| ack_req | output | 1 | With `frame_done`: the sender expects a reply |

## Verification
Random frames are sent to every address class: own unique, foreign unique, own group, foreign group, broadcast, master and reserved. This separates the acceptance and acknowledge decisions for each range. Random payload lengths, including 0 and the maximum of 200, and flipped checksum bits show whether the length counter and the CRC are right. Directed cases cover the rest:
- an oversized length byte followed by junk bytes;
- a truncated frame followed by a long silence;
- a frame whose bytes are spread just under the idle gap.

These tell discard-on-silence apart from tolerance of slow senders, and show recovery after a framing error.

// File: rtl/fbus_rx_pkg.sv
package fbus_rx_pkg;

   typedef enum logic [3:0] {
      ST_DST_HI,
      ST_DST_LO,
      ST_FCT_HI,
      ST_FCT_LO,
      ST_LEN,
      ST_DATA,
      ST_CRC_HI,
      ST_CRC_LO,
      ST_SKIP
   } rx_state_e;

   localparam logic [15:0] ADDR_UNI_LO = 16'd1000;
   localparam logic [15:0] ADDR_UNI_HI = 16'd64999;
   localparam logic [15:0] ADDR_GRP_LO = 16'd65000;
   localparam logic [15:0] ADDR_GRP_HI = 16'd65499;
   localparam logic [15:0] ADDR_BCAST  = 16'hFFFF;

endpackage

// File: rtl/fbus_crc16_step.sv
module fbus_crc16_step #(
   parameter logic [15:0] POLY    = 16'h8005,
   parameter bit          REFLECT = 1'b1
) (
   input  logic [15:0] crc_in,
   input  logic [7:0]  data_in,
   output logic [15:0] crc_out
);

   function automatic logic [15:0] bit_rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   localparam logic [15:0] RPOLY = bit_rev16(POLY);

   generate
      if (REFLECT) begin : g_lsb_first
         always_comb begin
            logic [15:0] c;
            c = crc_in ^ {8'h00, data_in};
            for (int i = 0; i < 8; i++)
               c = c[0] ? ((c >> 1) ^ RPOLY) : (c >> 1);
            crc_out = c;
         end
      end else begin : g_msb_first
         always_comb begin
            logic [15:0] c;
            c = crc_in ^ {data_in, 8'h00};
            for (int i = 0; i < 8; i++)
               c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
            crc_out = c;
         end
      end
   endgenerate

endmodule

// File: rtl/fbus_addr_class.sv
module fbus_addr_class
   import fbus_rx_pkg::*;
(
   input  logic [15:0] dst,
   input  logic [15:0] node_id,
   input  logic [15:0] group_id,
   output logic        hit,
   output logic        hit_unique
);

   logic in_uni, in_grp;

   always_comb begin
      in_uni     = (dst >= ADDR_UNI_LO) && (dst <= ADDR_UNI_HI);
      in_grp     = (dst >= ADDR_GRP_LO) && (dst <= ADDR_GRP_HI);
      hit_unique = in_uni && (dst == node_id);
      hit        = hit_unique || (in_grp && (dst == group_id)) || (dst == ADDR_BCAST);
   end

endmodule

// File: rtl/fbus_idle_gap.sv
module fbus_idle_gap #(
   parameter int GAP = 227865
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic byte_seen,
   output logic expired
);

   localparam int CW = $clog2(GAP + 1);
   localparam logic [CW-1:0] LIMIT = CW'(GAP - 1);

   logic [CW-1:0] cnt_q;

   assign expired = armed && !byte_seen && (cnt_q == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n || !armed || byte_seen || expired) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/fbus_frame_rx.sv
module fbus_frame_rx
   import fbus_rx_pkg::*;
#(
   parameter int          MAX_LEN     = 200,
   parameter int          IDLE_CYCLES = 227865,
   parameter logic [15:0] CRC_POLY    = 16'h8005,
   parameter bit          CRC_REFLECT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic [15:0] node_id,
   input  logic [15:0] group_id,
   output logic [15:0] fct_code,
   output logic        pl_valid,
   output logic [7:0]  pl_byte,
   output logic [7:0]  pl_index,
   output logic        frame_done,
   output logic        frame_ok,
   output logic        ack_req
);

   localparam logic [7:0] MAX_LEN_B = 8'(MAX_LEN);

   generate
      if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
         $error("fbus_frame_rx: MAX_LEN must be 1..255");
      end
      if (IDLE_CYCLES < 2) begin : g_bad_gap
         $error("fbus_frame_rx: IDLE_CYCLES must be at least 2");
      end
   endgenerate

   rx_state_e   st_q;
   logic [7:0]  dst_hi_q, fct_hi_q, crc_hi_q, len_q, cnt_q;
   logic [15:0] crc_q, crc_seed, crc_nx;
   logic        acc_q, uni_q;
   logic        hit, hit_unique, gap_expired;

   assign crc_seed = (st_q == ST_DST_HI) ? 16'hFFFF : crc_q;

   fbus_crc16_step #(.POLY(CRC_POLY), .REFLECT(CRC_REFLECT)) u_crc (
      .crc_in (crc_seed),
      .data_in(rx_byte),
      .crc_out(crc_nx)
   );

   fbus_addr_class u_cls (
      .dst       ({dst_hi_q, rx_byte}),
      .node_id   (node_id),
      .group_id  (group_id),
      .hit       (hit),
      .hit_unique(hit_unique)
   );

   fbus_idle_gap #(.GAP(IDLE_CYCLES)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (st_q != ST_DST_HI),
      .byte_seen(rx_valid),
      .expired  (gap_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_DST_HI;
         dst_hi_q   <= '0;
         fct_hi_q   <= '0;
         crc_hi_q   <= '0;
         len_q      <= '0;
         cnt_q      <= '0;
         crc_q      <= 16'hFFFF;
         acc_q      <= 1'b0;
         uni_q      <= 1'b0;
         fct_code   <= '0;
         pl_valid   <= 1'b0;
         pl_byte    <= '0;
         pl_index   <= '0;
         frame_done <= 1'b0;
         frame_ok   <= 1'b0;
         ack_req    <= 1'b0;
      end else begin
         pl_valid   <= 1'b0;
         frame_done <= 1'b0;
         ack_req    <= 1'b0;
         if (gap_expired) begin
            st_q <= ST_DST_HI;
         end else if (rx_valid) begin
            if (st_q != ST_CRC_HI && st_q != ST_CRC_LO && st_q != ST_SKIP)
               crc_q <= crc_nx;
            unique case (st_q)
               ST_DST_HI: begin
                  dst_hi_q <= rx_byte;
                  st_q     <= ST_DST_LO;
               end
               ST_DST_LO: begin
                  acc_q <= hit;
                  uni_q <= hit_unique;
                  st_q  <= ST_FCT_HI;
               end
               ST_FCT_HI: begin
                  fct_hi_q <= rx_byte;
                  st_q     <= ST_FCT_LO;
               end
               ST_FCT_LO: begin
                  fct_code <= {fct_hi_q, rx_byte};
                  st_q     <= ST_LEN;
               end
               ST_LEN: begin
                  len_q <= rx_byte;
                  cnt_q <= '0;
                  if (rx_byte > MAX_LEN_B) begin
                     frame_done <= acc_q;
                     frame_ok   <= 1'b0;
                     st_q       <= ST_SKIP;
                  end else if (rx_byte == 8'd0) begin
                     st_q <= ST_CRC_HI;
                  end else begin
                     st_q <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  pl_valid <= acc_q;
                  pl_byte  <= rx_byte;
                  pl_index <= cnt_q;
                  cnt_q    <= cnt_q + 8'd1;
                  if (cnt_q == len_q - 8'd1) st_q <= ST_CRC_HI;
               end
               ST_CRC_HI: begin
                  crc_hi_q <= rx_byte;
                  st_q     <= ST_CRC_LO;
               end
               ST_CRC_LO: begin
                  frame_done <= acc_q;
                  frame_ok   <= ({crc_hi_q, rx_byte} == crc_q);
                  ack_req    <= acc_q && uni_q && ({crc_hi_q, rx_byte} == crc_q);
                  st_q       <= ST_DST_HI;
               end
               ST_SKIP: st_q <= ST_SKIP;
               default: st_q <= ST_DST_HI;
            endcase
         end
      end
   end

endmodule

// File: rtl/fbus_frame_rx_chk.sv
module fbus_frame_rx_chk #(
   parameter int MAX_LEN = 200
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       pl_valid,
   input logic [7:0] pl_index,
   input logic       frame_done,
   input logic       frame_ok,
   input logic       ack_req
);

   logic [7:0] last_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        last_idx_q <= '0;
      else if (pl_valid) last_idx_q <= pl_index;
   end

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r11_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(rx_valid));

   a_r4_ack_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |-> (frame_done && frame_ok));

   a_r2_pl_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> ($past(rx_valid) && !frame_done));

   a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_valid && pl_index != 8'd0) |-> (pl_index == last_idx_q + 8'd1));

   a_r8_index_cap: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> (int'(pl_index) < MAX_LEN));

endmodule

bind fbus_frame_rx fbus_frame_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .pl_valid  (pl_valid),
   .pl_index  (pl_index),
   .frame_done(frame_done),
   .frame_ok  (frame_ok),
   .ack_req   (ack_req)
);

// File: tb/sim_fbus_frame_rx.sv
`timescale 1ns/1ps
module sim_fbus_frame_rx;

   localparam int GAP = 40;
   localparam logic [15:0] MY_ID  = 16'd4660;
   localparam logic [15:0] MY_GRP = 16'd65123;

   logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic [15:0] fct_code;
   logic pl_valid, frame_done, frame_ok, ack_req;
   logic [7:0] pl_byte, pl_index;

   always #2 clk = ~clk;

   fbus_frame_rx #(.IDLE_CYCLES(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .node_id(MY_ID), .group_id(MY_GRP), .fct_code(fct_code),
      .pl_valid(pl_valid), .pl_byte(pl_byte), .pl_index(pl_index),
      .frame_done(frame_done), .frame_ok(frame_ok), .ack_req(ack_req)
   );

   int checks = 0, fails = 0;
   bit finished = 0;
   int pl_cnt, done_cnt, idx_bad;
   logic got_ok, got_ack;
   logic [15:0] got_fct;
   logic [7:0] got_pl [0:255];
   logic [7:0] frm [0:263];
   logic [7:0] pay [0:255];

   always @(negedge clk) begin
      if (pl_valid) begin
         got_pl[pl_cnt[7:0]] = pl_byte;
         if (int'(pl_index) != pl_cnt) idx_bad++;
         pl_cnt++;
      end
      if (frame_done) begin
         done_cnt++;
         got_ok  = frame_ok;
         got_ack = ack_req;
         got_fct = fct_code;
      end
   end

   task automatic chk(input bit pass, input string req, input int act, input int exp);
      checks++;
      if (!pass) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_ref(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c ^= {8'h00, frm[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      end
      return c;
   endfunction

   function automatic bit exp_accept(input logic [15:0] a);
      return (a == 16'hFFFF) || (a >= 16'd65000 && a <= 16'd65499 && a == MY_GRP)
          || (a >= 16'd1000 && a <= 16'd64999 && a == MY_ID);
   endfunction

   function automatic string cls_tag(input logic [15:0] a);
      if (a == 16'hFFFF) return "R6";
      if (a >= 16'd65000 && a <= 16'd65499 && a == MY_GRP) return "R5";
      if (a >= 16'd1000 && a <= 16'd64999 && a == MY_ID) return "R4";
      return "R7";
   endfunction

   task automatic send_byte(input logic [7:0] b, input int gap);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic clear_mon();
      @(negedge clk);
      pl_cnt = 0; done_cnt = 0; idx_bad = 0; got_ok = 1'bx; got_ack = 1'bx;
   endtask

   // Full frame with len <= 200; flip corrupts the checksum
   task automatic run_frame(input logic [15:0] a, input logic [15:0] f, input int len,
                            input bit flip, input int gap);
      int n;
      logic [15:0] c;
      bit acc;
      clear_mon();
      frm[0] = a[15:8]; frm[1] = a[7:0]; frm[2] = f[15:8]; frm[3] = f[7:0];
      frm[4] = 8'(len);
      for (int i = 0; i < len; i++) begin
         pay[i] = 8'($urandom);
         frm[5+i] = pay[i];
      end
      n = 5 + len;
      c = crc_ref(n) ^ (flip ? 16'h0100 : 16'h0000);
      frm[n] = c[15:8]; frm[n+1] = c[7:0];
      for (int i = 0; i < n + 2; i++) send_byte(frm[i], gap);
      repeat (3) @(negedge clk);
      acc = exp_accept(a);
      chk(done_cnt == (acc ? 1 : 0), cls_tag(a), done_cnt, acc ? 1 : 0);
      if (acc) begin
         chk(got_ok == !flip, "R3", int'(got_ok), int'(!flip));
         chk(got_ack == (cls_tag(a) == "R4" && !flip), "R4", int'(got_ack),
             int'(cls_tag(a) == "R4" && !flip));
         chk(got_fct == f, "R1", int'(got_fct), int'(f));
         chk(pl_cnt == len, len == 0 ? "R9" : "R2", pl_cnt, len);
         chk(idx_bad == 0, "R2", idx_bad, 0);
         for (int i = 0; i < len && i < pl_cnt; i++)
            if (got_pl[i] != pay[i]) chk(0, "R2", int'(got_pl[i]), int'(pay[i]));
      end else begin
         chk(pl_cnt == 0, "R7", pl_cnt, 0);
      end
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom_range(0, 7))
         0, 1: return MY_ID;
         2: return 16'($urandom_range(1000, 64999));
         3: return MY_GRP;
         4: return 16'($urandom_range(65000, 65499));
         5: return 16'hFFFF;
         6: return 16'd0;
         default: return ($urandom_range(0, 1) != 0) ? 16'($urandom_range(1, 999))
                                                    : 16'($urandom_range(65500, 65534));
      endcase
   endfunction

   initial begin
      #(4 * 190000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      pl_cnt = 0; done_cnt = 0; idx_bad = 0;
      repeat (5) @(negedge clk);
      chk(!frame_done && !pl_valid && !ack_req && fct_code == 16'h0, "R11", int'(frame_done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Directed: each address class
      run_frame(MY_ID, 16'hA55A, 4, 0, 0);
      run_frame(MY_ID, 16'h0102, 4, 1, 1);
      run_frame(MY_GRP, 16'h1234, 3, 0, 0);
      run_frame(16'd65124, 16'h1234, 3, 0, 0);
      run_frame(16'hFFFF, 16'hBEEF, 2, 0, 0);
      run_frame(16'd0, 16'h0001, 2, 0, 0);
      run_frame(16'd999, 16'h0001, 2, 0, 0);
      run_frame(16'd65500, 16'h0001, 2, 0, 0);
      run_frame(16'd4661, 16'h0001, 2, 0, 0);
      run_frame(MY_ID, 16'h7777, 0, 0, 0);     // R9 zero length
      run_frame(MY_ID, 16'h8888, 200, 0, 0);   // R2 full payload
      run_frame(MY_ID, 16'h4242, 3, 0, GAP - 5); // R10 slow but intact

      // R8: oversized length addressed here, junk follows
      clear_mon();
      send_byte(MY_ID[15:8], 0); send_byte(MY_ID[7:0], 0);
      send_byte(8'h00, 0); send_byte(8'h05, 0); send_byte(8'd201, 0);
      for (int i = 0; i < 6; i++) send_byte(8'h55, 0);
      repeat (GAP + 5) @(negedge clk);
      chk(done_cnt == 1, "R8", done_cnt, 1);
      chk(got_ok == 1'b0, "R8", int'(got_ok), 0);
      chk(pl_cnt == 0, "R8", pl_cnt, 0);
      run_frame(MY_ID, 16'h0303, 2, 0, 0);     // R8 recovery after gap

      // R10: truncated frame then silence
      clear_mon();
      send_byte(MY_ID[15:8], 0); send_byte(MY_ID[7:0], 0); send_byte(8'h11, 0);
      repeat (GAP + 5) @(negedge clk);
      chk(done_cnt == 0, "R10", done_cnt, 0);
      run_frame(MY_ID, 16'h0404, 5, 0, 0);

      // Random mix
      for (int k = 0; k < 60; k++) begin
         int len;
         len = ($urandom_range(0, 9) == 0) ? int'($urandom_range(150, 200))
                                           : int'($urandom_range(0, 12));
         run_frame(pick_addr(), 16'($urandom), len, $urandom_range(0, 3) == 0, 0);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule